// File: doc/BRIEF.md
# Ordering-Aware Store Write Buffer

This block sits between a core's retirement stage and its data cache. Each retired store arrives as a word address, a data word, a byte-enable mask and a flag that marks it as a release. The store waits in one of eight slots until the cache-side port has taken it and acknowledged it. A single mode input picks the drain policy. In strict mode, stores leave in program order. In relaxed mode, any slot whose ordering constraints are met may leave. A store may not overtake an older release or an older store to the same word. A release may not leave until every older store has been acknowledged.

A separate sync port carries fences and atomic operations, which both need the same thing: every store older than the request must have been performed before the request completes. While a sync request is outstanding, no new stores are accepted. A load-side lookup compares a load's word address and byte mask against the buffered stores. It reports a forwardable hit with data from the youngest overlapping store, a stall when that store does not cover every requested byte, or a miss.

Top module: `store_write_buffer`

## Requirements
- R1: With `mode`=0 (strict), `mem_valid` always presents the oldest store that has not yet been handed off. Several stores may be in flight at once, but they are handed off strictly in program order.
- R2: With `mode`=1 (relaxed), new stores fill the lowest-numbered free slot. Among the slots whose constraints are met, the lowest-numbered slot is offered, even when older stores are still waiting.
- R3: With `mode`=1, a store is not offered while any older store flagged as a release is still in the buffer, whether handed off or not.
- R4: With `mode`=1, a release store is not offered until every older store has been acknowledged.
- R5: With `mode`=1, a store is not offered while an older store to the same word address is still in the buffer.
- R6: `st_ready` is 0 whenever all 8 slots are occupied. A store presented while `st_ready` is 0 is not buffered. An acknowledgement frees its slot and raises `st_ready` again.
- R7: A slot is handed off once, on the cycle where `mem_valid` and `mem_ready` are both 1, and is never offered again. It stays buffered until `mem_ack` is 1 with `mem_ack_tag` equal to the `mem_tag` it was issued with.
- R8: A `sync_req` taken while `sync_busy` is 0 raises `sync_busy` and drops `st_ready`. A store accepted in the same cycle counts as older. `sync_done` is 1 for exactly one cycle, the first cycle after the acknowledgement that removes the last older store. `sync_busy` falls on the following cycle.
- R9: A `sync_req` taken while the buffer is empty gives `sync_done`=1 in the cycle right after the request.
- R10: When the youngest buffered store that overlaps a load's word address and byte mask covers every requested byte, `ld_hit` is 1 and `ld_data` is that store's whole data word.
- R11: When that youngest overlapping store misses any requested byte, `ld_stall` is 1 and `ld_hit` is 0. With no overlapping store (a different word, or disjoint masks), both are 0. Both are 0 when `ld_valid` is 0.
- R12: After reset the buffer is empty: `st_ready`=1, `mem_valid`=0, `sync_busy`=0 and `sync_done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | Drain policy: 0 strict order, 1 relaxed |
| st_valid | input | 1 | Retired store presented |
| st_ready | output | 1 | Store can be accepted this cycle |
| st_waddr | input | 30 | Store word address |
| st_data | input | 32 | Store data word |
| st_mask | input | 4 | Store byte enables |
| st_rel | input | 1 | Store carries release semantics |
| sync_req | input | 1 | Fence or atomic ordering request |
| sync_busy | output | 1 | A sync request is outstanding |
| sync_done | output | 1 | Outstanding sync request completes |
| ld_valid | input | 1 | Load lookup valid |
| ld_waddr | input | 30 | Load word address |
| ld_mask | input | 4 | Load byte enables |
| ld_hit | output | 1 | Forwardable match |
| ld_stall | output | 1 | Partial overlap, load must wait |
| ld_data | output | 32 | Forwarded data word |
| mem_valid | output | 1 | Write offered to cache |
| mem_ready | input | 1 | Cache takes the offered write |
| mem_waddr | output | 30 | Offered word address |
| mem_data | output | 32 | Offered data |
| mem_mask | output | 4 | Offered byte enables |
| mem_tag | output | 3 | Slot number of the offered write |
| mem_ack | input | 1 | Write performed |
| mem_ack_tag | input | 3 | Slot number being acknowledged |

## Verification
On every cycle, the assertions compare each offered slot against program order. They track program order with their own sequence numbers, not with the design's age matrix. They check that strict mode offers the oldest unissued store, that a relaxed-mode store is never offered past an older release, and that a release is only offered once it is the oldest store still buffered. They also check that a completed sync leaves no older store behind, that a full or syncing buffer refuses stores, and that hit and stall never coincide. The directed scenarios show things a single-cycle property cannot: the actual order in which addresses reach the cache, a relaxed drain overtaking older stores through slot reuse, same-word blocking, the one-cycle timing of `sync_done`, and the forwarded data values.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

    localparam int WADDR_W = 30;
    localparam int DATA_W  = 32;
    localparam int DEPTH   = 8;
    localparam int BYTES   = DATA_W / 8;
    localparam int IDX_W   = $clog2(DEPTH);

    typedef enum logic {
        ORDER_STRICT  = 1'b0,
        ORDER_RELAXED = 1'b1
    } order_mode_e;

    typedef struct packed {
        logic [WADDR_W-1:0] waddr;
        logic [DATA_W-1:0]  data;
        logic [BYTES-1:0]   mask;
        logic               rel;
    } slot_t;

    // index of lowest set bit; zero when none set
    function automatic logic [IDX_W-1:0] lowest_one(input logic [DEPTH-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (v[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/sb_age.sv
// Age matrix: older[r][c] set means slot c entered before slot r.
module sb_age
    import sbuf_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        alloc_fire,
    input  logic [IDX_W-1:0]            alloc_idx,
    input  logic [DEPTH-1:0]            valid,
    output logic [DEPTH-1:0][DEPTH-1:0] older
);

    always_ff @(posedge clk) begin
        if (rst) begin
            older <= '0;
        end else if (alloc_fire) begin
            for (int r = 0; r < DEPTH; r++) begin
                if (alloc_idx == IDX_W'(r)) begin
                    older[r] <= valid;
                end else begin
                    older[r][alloc_idx] <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/sb_drain_pick.sv
// Chooses the slot offered to the cache under the selected ordering policy.
module sb_drain_pick
    import sbuf_pkg::*;
(
    input  logic                          mode,
    input  logic [DEPTH-1:0]              valid,
    input  logic [DEPTH-1:0]              issued,
    input  logic [DEPTH-1:0]              rel,
    input  logic [DEPTH-1:0][WADDR_W-1:0] waddr,
    input  logic [DEPTH-1:0][DEPTH-1:0]   older,
    output logic                          pick_valid,
    output logic [IDX_W-1:0]              pick_idx
);

    logic [DEPTH-1:0] elig;
    logic [DEPTH-1:0] live_older;
    logic [DEPTH-1:0] same_word;
    logic             any_older;
    logic             rel_older;
    logic             wait_older;
    logic             same_older;

    always_comb begin
        elig       = '0;
        live_older = '0;
        same_word  = '0;
        any_older  = 1'b0;
        rel_older  = 1'b0;
        wait_older = 1'b0;
        same_older = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            live_older = older[i] & valid;
            for (int j = 0; j < DEPTH; j++) begin
                same_word[j] = (waddr[j] == waddr[i]);
            end
            any_older  = |live_older;
            rel_older  = |(live_older & rel);
            wait_older = |(live_older & ~issued);
            same_older = |(live_older & same_word);
            if (valid[i] && !issued[i]) begin
                if (order_mode_e'(mode) == ORDER_STRICT) begin
                    elig[i] = !wait_older;
                end else begin
                    elig[i] = !rel_older && !same_older && !(rel[i] && any_older);
                end
            end
        end
    end

    assign pick_valid = |elig;
    assign pick_idx   = lowest_one(elig);

endmodule

// File: rtl/sb_load_lookup.sv
// Matches a load against buffered stores; youngest overlapping store decides.
module sb_load_lookup
    import sbuf_pkg::*;
(
    input  logic                          ld_valid,
    input  logic [WADDR_W-1:0]            ld_waddr,
    input  logic [BYTES-1:0]              ld_mask,
    input  logic [DEPTH-1:0]              valid,
    input  logic [DEPTH-1:0][WADDR_W-1:0] waddr,
    input  logic [DEPTH-1:0][BYTES-1:0]   mask,
    input  logic [DEPTH-1:0][DATA_W-1:0]  data,
    input  logic [DEPTH-1:0][DEPTH-1:0]   older,
    output logic                          hit,
    output logic                          stall,
    output logic [DATA_W-1:0]             fwd_data
);

    logic [DEPTH-1:0]  match;
    logic [DEPTH-1:0]  youngest;
    logic [BYTES-1:0]  sel_mask;
    logic              covered;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            match[i] = valid[i] && (waddr[i] == ld_waddr) && (|(mask[i] & ld_mask));
        end
        for (int i = 0; i < DEPTH; i++) begin
            youngest[i] = match[i];
            for (int j = 0; j < DEPTH; j++) begin
                if (match[j] && older[j][i]) youngest[i] = 1'b0;
            end
        end
        sel_mask = '0;
        fwd_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (youngest[i]) begin
                sel_mask = sel_mask | mask[i];
                fwd_data = fwd_data | data[i];
            end
        end
        covered = ((ld_mask & ~sel_mask) == '0);
    end

    assign hit   = ld_valid && (|match) && covered;
    assign stall = ld_valid && (|match) && !covered;

endmodule

// File: rtl/sb_sync_track.sv
// Holds a fence/atomic until every store older than it has been performed.
module sb_sync_track
    import sbuf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_req,
    input  logic             alloc_fire,
    input  logic [IDX_W-1:0] alloc_idx,
    input  logic [DEPTH-1:0] valid,
    output logic             busy,
    output logic             done
);

    logic             pend_q;
    logic [DEPTH-1:0] snap_q;
    logic [DEPTH-1:0] alloc_vec;

    always_comb begin
        alloc_vec = '0;
        if (alloc_fire) alloc_vec[alloc_idx] = 1'b1;
    end

    assign busy = pend_q;
    assign done = pend_q && ((snap_q & valid) == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            snap_q <= '0;
        end else if (!pend_q) begin
            if (sync_req) begin
                pend_q <= 1'b1;
                snap_q <= valid | alloc_vec;
            end
        end else if (done) begin
            pend_q <= 1'b0;
            snap_q <= '0;
        end
    end

endmodule

// File: rtl/store_write_buffer.sv
module store_write_buffer
    import sbuf_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               mode,
    input  logic               st_valid,
    output logic               st_ready,
    input  logic [WADDR_W-1:0] st_waddr,
    input  logic [DATA_W-1:0]  st_data,
    input  logic [BYTES-1:0]   st_mask,
    input  logic               st_rel,
    input  logic               sync_req,
    output logic               sync_busy,
    output logic               sync_done,
    input  logic               ld_valid,
    input  logic [WADDR_W-1:0] ld_waddr,
    input  logic [BYTES-1:0]   ld_mask,
    output logic               ld_hit,
    output logic               ld_stall,
    output logic [DATA_W-1:0]  ld_data,
    output logic               mem_valid,
    input  logic               mem_ready,
    output logic [WADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0]  mem_data,
    output logic [BYTES-1:0]   mem_mask,
    output logic [IDX_W-1:0]   mem_tag,
    input  logic               mem_ack,
    input  logic [IDX_W-1:0]   mem_ack_tag
);

    slot_t                         slot_q [DEPTH];
    logic [DEPTH-1:0]              ent_valid;
    logic [DEPTH-1:0]              ent_issued;
    logic [DEPTH-1:0]              ent_rel;
    logic [DEPTH-1:0][WADDR_W-1:0] waddr_v;
    logic [DEPTH-1:0][DATA_W-1:0]  data_v;
    logic [DEPTH-1:0][BYTES-1:0]   mask_v;
    logic [DEPTH-1:0][DEPTH-1:0]   older;

    logic             full;
    logic [IDX_W-1:0] alloc_idx;
    logic             alloc_fire;
    logic             issue_fire;
    logic             pick_valid;
    logic [IDX_W-1:0] pick_idx;

    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
        assign waddr_v[g] = slot_q[g].waddr;
        assign data_v[g]  = slot_q[g].data;
        assign mask_v[g]  = slot_q[g].mask;
        assign ent_rel[g] = slot_q[g].rel;
    end

    assign full       = &ent_valid;
    assign alloc_idx  = lowest_one(~ent_valid);
    assign st_ready   = !full && !sync_busy;
    assign alloc_fire = st_valid && st_ready;
    assign issue_fire = mem_valid && mem_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_valid  <= '0;
            ent_issued <= '0;
        end else begin
            if (alloc_fire) begin
                ent_valid[alloc_idx]  <= 1'b1;
                ent_issued[alloc_idx] <= 1'b0;
            end
            if (issue_fire) begin
                ent_issued[pick_idx] <= 1'b1;
            end
            if (mem_ack) begin
                ent_valid[mem_ack_tag] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (alloc_fire) begin
            slot_q[alloc_idx] <= '{waddr: st_waddr, data: st_data, mask: st_mask, rel: st_rel};
        end
    end

    sb_age u_age (
        .clk        (clk),
        .rst        (rst),
        .alloc_fire (alloc_fire),
        .alloc_idx  (alloc_idx),
        .valid      (ent_valid),
        .older      (older)
    );

    sb_drain_pick u_pick (
        .mode       (mode),
        .valid      (ent_valid),
        .issued     (ent_issued),
        .rel        (ent_rel),
        .waddr      (waddr_v),
        .older      (older),
        .pick_valid (pick_valid),
        .pick_idx   (pick_idx)
    );

    sb_load_lookup u_lookup (
        .ld_valid (ld_valid),
        .ld_waddr (ld_waddr),
        .ld_mask  (ld_mask),
        .valid    (ent_valid),
        .waddr    (waddr_v),
        .mask     (mask_v),
        .data     (data_v),
        .older    (older),
        .hit      (ld_hit),
        .stall    (ld_stall),
        .fwd_data (ld_data)
    );

    sb_sync_track u_sync (
        .clk        (clk),
        .rst        (rst),
        .sync_req   (sync_req),
        .alloc_fire (alloc_fire),
        .alloc_idx  (alloc_idx),
        .valid      (ent_valid),
        .busy       (sync_busy),
        .done       (sync_done)
    );

    assign mem_valid = pick_valid;
    assign mem_tag   = pick_idx;
    assign mem_waddr = slot_q[pick_idx].waddr;
    assign mem_data  = slot_q[pick_idx].data;
    assign mem_mask  = slot_q[pick_idx].mask;

endmodule

// File: rtl/sb_order_checker.sv
// Tracks program order with independent sequence numbers.
module sb_order_checker
    import sbuf_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             mode,
    input logic             st_ready,
    input logic             alloc_fire,
    input logic [IDX_W-1:0] alloc_idx,
    input logic             mem_valid,
    input logic [IDX_W-1:0] mem_tag,
    input logic [DEPTH-1:0] ent_valid,
    input logic [DEPTH-1:0] ent_issued,
    input logic [DEPTH-1:0] ent_rel,
    input logic             sync_req,
    input logic             sync_busy,
    input logic             sync_done,
    input logic             ld_hit,
    input logic             ld_stall
);

    logic [31:0] seq_q [DEPTH];
    logic [31:0] cnt_q;
    logic [31:0] bound_q;
    logic [31:0] min_all;
    logic [31:0] min_open;
    logic        rel_before;
    logic        older_live;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            bound_q <= '0;
        end else begin
            if (alloc_fire) begin
                seq_q[alloc_idx] <= cnt_q;
                cnt_q            <= cnt_q + 32'd1;
            end
            if (sync_req && !sync_busy) begin
                bound_q <= cnt_q + (alloc_fire ? 32'd1 : 32'd0);
            end
        end
    end

    always_comb begin
        min_all    = '1;
        min_open   = '1;
        rel_before = 1'b0;
        older_live = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ent_valid[i]) begin
                if (seq_q[i] < min_all) min_all = seq_q[i];
                if (!ent_issued[i] && seq_q[i] < min_open) min_open = seq_q[i];
                if (ent_rel[i] && seq_q[i] < seq_q[mem_tag]) rel_before = 1'b1;
                if (seq_q[i] < bound_q) older_live = 1'b1;
            end
        end
    end

    p_strict_order_r1: assert property (@(posedge clk) disable iff (rst)
        (!mode && mem_valid) |-> (seq_q[mem_tag] == min_open));

    p_no_pass_release_r3: assert property (@(posedge clk) disable iff (rst)
        (mode && mem_valid) |-> !rel_before);

    p_release_oldest_r4: assert property (@(posedge clk) disable iff (rst)
        (mode && mem_valid && ent_rel[mem_tag]) |-> (seq_q[mem_tag] == min_all));

    p_full_refuse_r6: assert property (@(posedge clk) disable iff (rst)
        (&ent_valid) |-> !st_ready);

    p_issue_once_r7: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (ent_valid[mem_tag] && !ent_issued[mem_tag]));

    p_sync_complete_r8: assert property (@(posedge clk) disable iff (rst)
        sync_done |-> !older_live);

    p_sync_hold_r8: assert property (@(posedge clk) disable iff (rst)
        sync_busy |-> !st_ready);

    p_sync_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        sync_done |=> !sync_busy);

    p_hit_stall_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(ld_hit && ld_stall));

endmodule

bind store_write_buffer sb_order_checker u_order_checker (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .st_ready   (st_ready),
    .alloc_fire (alloc_fire),
    .alloc_idx  (alloc_idx),
    .mem_valid  (mem_valid),
    .mem_tag    (mem_tag),
    .ent_valid  (ent_valid),
    .ent_issued (ent_issued),
    .ent_rel    (ent_rel),
    .sync_req   (sync_req),
    .sync_busy  (sync_busy),
    .sync_done  (sync_done),
    .ld_hit     (ld_hit),
    .ld_stall   (ld_stall)
);

// File: tb/tb_store_write_buffer.sv
`timescale 1ns/1ps
module tb_store_write_buffer;
    import sbuf_pkg::*;

    logic               clk = 1'b0;
    logic               rst;
    logic               mode;
    logic               st_valid;
    logic               st_ready;
    logic [WADDR_W-1:0] st_waddr;
    logic [DATA_W-1:0]  st_data;
    logic [BYTES-1:0]   st_mask;
    logic               st_rel;
    logic               sync_req;
    logic               sync_busy;
    logic               sync_done;
    logic               ld_valid;
    logic [WADDR_W-1:0] ld_waddr;
    logic [BYTES-1:0]   ld_mask;
    logic               ld_hit;
    logic               ld_stall;
    logic [DATA_W-1:0]  ld_data;
    logic               mem_valid;
    logic               mem_ready;
    logic [WADDR_W-1:0] mem_waddr;
    logic [DATA_W-1:0]  mem_data;
    logic [BYTES-1:0]   mem_mask;
    logic [IDX_W-1:0]   mem_tag;
    logic               mem_ack;
    logic [IDX_W-1:0]   mem_ack_tag;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    store_write_buffer dut (
        .clk(clk), .rst(rst), .mode(mode),
        .st_valid(st_valid), .st_ready(st_ready), .st_waddr(st_waddr),
        .st_data(st_data), .st_mask(st_mask), .st_rel(st_rel),
        .sync_req(sync_req), .sync_busy(sync_busy), .sync_done(sync_done),
        .ld_valid(ld_valid), .ld_waddr(ld_waddr), .ld_mask(ld_mask),
        .ld_hit(ld_hit), .ld_stall(ld_stall), .ld_data(ld_data),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_waddr(mem_waddr),
        .mem_data(mem_data), .mem_mask(mem_mask), .mem_tag(mem_tag),
        .mem_ack(mem_ack), .mem_ack_tag(mem_ack_tag)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset(input logic m);
        rst = 1'b1; mode = m; st_valid = 0; st_waddr = '0; st_data = '0; st_mask = '0;
        st_rel = 0; sync_req = 0; ld_valid = 0; ld_waddr = '0; ld_mask = '0;
        mem_ready = 0; mem_ack = 0; mem_ack_tag = '0;
        step(); step();
        rst = 1'b0;
        step();
    endtask

    task automatic push(input logic [WADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                        input logic [BYTES-1:0] m, input logic r);
        st_valid = 1; st_waddr = a; st_data = d; st_mask = m; st_rel = r;
        step();
        st_valid = 0;
    endtask

    task automatic take(input logic [WADDR_W-1:0] exp_a, input string req);
        #1;
        chk(mem_valid === 1'b1, req, {63'd0, mem_valid}, 64'd1);
        chk(mem_waddr === exp_a, req, 64'(mem_waddr), 64'(exp_a));
        mem_ready = 1;
        step();
        mem_ready = 0;
    endtask

    task automatic ack(input logic [IDX_W-1:0] t);
        mem_ack = 1; mem_ack_tag = t;
        step();
        mem_ack = 0;
    endtask

    task automatic look(input logic [WADDR_W-1:0] a, input logic [BYTES-1:0] m,
                        input logic e_hit, input logic e_stall, input logic [DATA_W-1:0] e_data,
                        input string req);
        ld_valid = 1; ld_waddr = a; ld_mask = m;
        #1;
        chk(ld_hit === e_hit, req, {63'd0, ld_hit}, {63'd0, e_hit});
        chk(ld_stall === e_stall, req, {63'd0, ld_stall}, {63'd0, e_stall});
        if (e_hit) chk(ld_data === e_data, req, 64'(ld_data), 64'(e_data));
        step();
        ld_valid = 0;
    endtask

    task automatic t_reset_state();
        do_reset(1'b0);
        chk(st_ready === 1'b1, "R12 st_ready", {63'd0, st_ready}, 64'd1);
        chk(mem_valid === 1'b0, "R12 mem_valid", {63'd0, mem_valid}, 64'd0);
        chk(sync_busy === 1'b0, "R12 sync_busy", {63'd0, sync_busy}, 64'd0);
        chk(sync_done === 1'b0, "R12 sync_done", {63'd0, sync_done}, 64'd0);
    endtask

    task automatic t_strict_order();
        do_reset(1'b0);
        push(30'h100, 32'hA0, 4'hF, 1'b0);
        push(30'h204, 32'hA1, 4'hF, 1'b0);
        push(30'h308, 32'hA2, 4'hF, 1'b0);
        push(30'h40C, 32'hA3, 4'hF, 1'b1);
        take(30'h100, "R1 first");
        take(30'h204, "R1 second pipelined, R7 slot0 not reoffered");
        take(30'h308, "R1 third");
        take(30'h40C, "R1 fourth");
        #1;
        chk(mem_valid === 1'b0, "R7 nothing left to offer", {63'd0, mem_valid}, 64'd0);
        for (int i = 0; i < 4; i++) ack(IDX_W'(i));
        look(30'h100, 4'hF, 1'b0, 1'b0, '0, "R7 slot freed on ack");
    endtask

    task automatic t_full();
        do_reset(1'b0);
        for (int i = 0; i < DEPTH; i++) push(WADDR_W'(32'h40 * (i + 1)), DATA_W'(i), 4'hF, 1'b0);
        #1;
        chk(st_ready === 1'b0, "R6 full", {63'd0, st_ready}, 64'd0);
        push(30'hF00, 32'hDEAD, 4'hF, 1'b0);
        look(30'hF00, 4'hF, 1'b0, 1'b0, '0, "R6 refused store absent");
        take(30'h40, "R6 drain oldest");
        ack(3'd0);
        #1;
        chk(st_ready === 1'b1, "R6 ready after ack", {63'd0, st_ready}, 64'd1);
    endtask

    task automatic t_reuse(input logic m, input logic [WADDR_W-1:0] exp_a, input string req);
        do_reset(m);
        for (int i = 0; i < DEPTH; i++) push(WADDR_W'(32'h1000 + i), DATA_W'(i), 4'hF, 1'b0);
        take(30'h1000, req);
        ack(3'd0);
        push(30'h2000, 32'h77, 4'hF, 1'b0);
        take(exp_a, req);
    endtask

    task automatic t_same_word(input logic m, input logic [WADDR_W-1:0] exp_a, input string req);
        do_reset(m);
        push(30'h300, 32'h1, 4'hF, 1'b0);
        push(30'h300, 32'h2, 4'hF, 1'b0);
        push(30'h400, 32'h3, 4'hF, 1'b0);
        take(30'h300, req);
        take(exp_a, req);
    endtask

    task automatic t_release();
        do_reset(1'b1);
        push(30'h500, 32'h5, 4'hF, 1'b0);
        push(30'h600, 32'h6, 4'hF, 1'b1);
        push(30'h700, 32'h7, 4'hF, 1'b0);
        take(30'h500, "R3 oldest plain store");
        #1;
        chk(mem_valid === 1'b0, "R4 release waits for ack", {63'd0, mem_valid}, 64'd0);
        ack(3'd0);
        take(30'h600, "R4 release after ack");
        #1;
        chk(mem_valid === 1'b0, "R3 younger waits on release", {63'd0, mem_valid}, 64'd0);
        ack(3'd1);
        take(30'h700, "R3 younger after release acked");
    endtask

    task automatic t_sync();
        do_reset(1'b0);
        push(30'h10, 32'h1, 4'hF, 1'b0);
        push(30'h20, 32'h2, 4'hF, 1'b0);
        sync_req = 1;
        step();
        sync_req = 0;
        #1;
        chk(sync_busy === 1'b1, "R8 busy", {63'd0, sync_busy}, 64'd1);
        chk(sync_done === 1'b0, "R8 not done", {63'd0, sync_done}, 64'd0);
        chk(st_ready === 1'b0, "R8 stores held", {63'd0, st_ready}, 64'd0);
        take(30'h10, "R8 drain a");
        take(30'h20, "R8 drain b");
        ack(3'd0);
        #1;
        chk(sync_done === 1'b0, "R8 one store left", {63'd0, sync_done}, 64'd0);
        ack(3'd1);
        #1;
        chk(sync_done === 1'b1, "R8 done after last ack", {63'd0, sync_done}, 64'd1);
        step();
        #1;
        chk(sync_done === 1'b0, "R8 single pulse", {63'd0, sync_done}, 64'd0);
        chk(sync_busy === 1'b0, "R8 busy cleared", {63'd0, sync_busy}, 64'd0);
        chk(st_ready === 1'b1, "R8 stores resume", {63'd0, st_ready}, 64'd1);
        sync_req = 1;
        step();
        sync_req = 0;
        #1;
        chk(sync_done === 1'b1, "R9 empty buffer done", {63'd0, sync_done}, 64'd1);
        step();
        #1;
        chk(sync_done === 1'b0, "R9 pulse ends", {63'd0, sync_done}, 64'd0);
    endtask

    task automatic t_lookup();
        do_reset(1'b0);
        push(30'h800, 32'h1111_1111, 4'hF, 1'b0);
        push(30'h800, 32'h2222_2222, 4'hF, 1'b0);
        push(30'h900, 32'h0000_BEEF, 4'h3, 1'b0);
        look(30'h800, 4'hF, 1'b1, 1'b0, 32'h2222_2222, "R10 youngest full");
        look(30'h800, 4'h4, 1'b1, 1'b0, 32'h2222_2222, "R10 single byte");
        look(30'h900, 4'h1, 1'b1, 1'b0, 32'h0000_BEEF, "R10 covered partial");
        look(30'hA00, 4'hF, 1'b0, 1'b0, '0, "R11 other word");
        look(30'h900, 4'hF, 1'b0, 1'b1, '0, "R11 partial stall");
        look(30'h900, 4'hC, 1'b0, 1'b0, '0, "R11 disjoint bytes");
        push(30'h800, 32'h0000_0033, 4'h1, 1'b0);
        look(30'h800, 4'hF, 1'b0, 1'b1, '0, "R11 youngest partial");
        #1;
        chk(ld_hit === 1'b0 && ld_stall === 1'b0, "R11 idle lookup",
            {62'd0, ld_hit, ld_stall}, 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        step();
        t_reset_state();
        t_strict_order();
        t_full();
        t_reuse(1'b1, 30'h2000, "R2 relaxed drains reused low slot");
        t_reuse(1'b0, 30'h1001, "R1 strict drains oldest");
        t_same_word(1'b1, 30'h400, "R5 same word blocked");
        t_same_word(1'b0, 30'h300, "R1 strict same word");
        t_release();
        t_sync();
        t_lookup();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule